// File: doc/BRIEF.md
# Dual-Mode Error Pulse Monitor

This block supervises the error-signalling line of a microcontroller and judges the timing of its pulses. The line is asynchronous to the block. It is first brought through a flop synchronizer. The time between its edges is then measured in ticks of an enable strobe, so the same logic covers slow and fast timing ranges without a change of clock.

Two checking schemes share one timing engine, and a mode input selects between them. In the low-pulse scheme, only low pulses are judged, and the test is that none is longer than a programmed maximum. In the PWM scheme, every low phase and every high phase must fall inside its own programmed minimum and maximum. In both schemes, a period with no progress that is longer than the sum of the two maximum thresholds is also an error. A surrounding safety controller consumes the single-cycle error and correct pulses, for example to drive a failure counter.

Top module: `err_pulse_mon`

## Requirements
- R1: After reset, `err_o` and `ok_o` are low. While `en_i` is low, no pulse is produced. Clearing `en_i` abandons any measurement in progress, and enabling again starts a fresh cycle from the current level of the pin.
- R2: In low-pulse mode (`mode_pwm_i`=0) with the pin high at enable, checking starts at the first falling edge. A low phase that lasts at most `lo_max_i` ticks and ends in a rising edge gives one `ok_o` pulse. A pin that stays high produces nothing.
- R3: In low-pulse mode, a low phase longer than `lo_max_i` ticks gives one `err_o` pulse. The pulse is raised in the cycle the count exceeds the limit, before the pin returns high.
- R4: In low-pulse mode with the pin low, a wait longer than `lo_max_i`+`hi_max_i` ticks without a rising edge gives `err_o`, and the wait restarts. With a tick every cycle, successive errors are exactly `lo_max_i`+`hi_max_i`+2 cycles apart.
- R5: In PWM mode (`mode_pwm_i`=1), measurement starts at the first edge of either polarity. Two consecutive in-range phases (low in [`lo_min_i`,`lo_max_i`], high in [`hi_min_i`,`hi_max_i`], inclusive, either order) give one `ok_o` pulse. The edge that closes the pair only ends it, and the following edge starts the next cycle.
- R6: In PWM mode, a phase that ends with fewer ticks than its minimum gives `err_o` at its closing edge. That edge does not start a new measurement.
- R7: In PWM mode, a phase that exceeds its maximum gives `err_o` in the cycle its count first passes the maximum, without waiting for an edge. If the closing edge arrives in that same cycle, it does not start a new measurement. Otherwise the next edge does.
- R8: In PWM mode, waiting for a first edge longer than `lo_max_i`+`hi_max_i` ticks gives `err_o`, repeated every `lo_max_i`+`hi_max_i`+2 cycles with a tick every cycle.
- R9: A change of `mode_pwm_i` while enabled produces no pulse in the next cycle and restarts monitoring in the new mode. A measurement in progress is then never reported.
- R10: Durations count only cycles with `tick_i` high. The counter saturates and never wraps.
- R11: `err_o` and `ok_o` are never high together, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcu_err_i | input | 1 | Monitored pin, asynchronous |
| tick_i | input | 1 | Time-base strobe; one tick per high cycle |
| en_i | input | 1 | Monitor enable |
| mode_pwm_i | input | 1 | 0 = low-pulse mode, 1 = PWM mode |
| lo_min_i | input | CW | Minimum low phase, ticks (PWM mode) |
| lo_max_i | input | CW | Maximum low phase, ticks |
| hi_min_i | input | CW | Minimum high phase, ticks (PWM mode) |
| hi_max_i | input | CW | Maximum high phase, ticks |
| err_o | output | 1 | Single-cycle error pulse |
| ok_o | output | 1 | Single-cycle correct-signalling pulse |

## Verification
Random phase trains are applied in both modes. Their lengths range from one cycle to three past the applicable maximum, and the bench predicts error and correct counts phase by phase. This separates edge-time judgement from mid-phase over-maximum detection, and it separates the measured phases from the ones skipped after a cycle restarts. Directed cases then pin the boundaries: exactly the minimum, exactly the maximum, and one past it. They also cover the spacing of repeated start-up and no-edge time-outs, a tick every other cycle (which halves the apparent length), and a mode change or enable drop during a pulse that would otherwise have failed.

// File: rtl/epm_pkg.sv
package epm_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_LP_ARM,
    ST_LP_LOW,
    ST_LP_START,
    ST_PW_WAIT,
    ST_PW_PH1,
    ST_PW_PH2
  } epm_state_e;
endpackage

// File: rtl/epm_sync.sv
module epm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/epm_timer.sv
module epm_timer #(
  parameter int CW = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        restart_i,
  input  logic        edge_i,
  input  logic        tick_i,
  output logic [CW:0] cnt_o
);
  localparam logic [CW:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_o <= '0;
    else if (restart_i)               cnt_o <= '0;
    else if (edge_i)                  cnt_o <= {{CW{1'b0}}, tick_i};
    else if (tick_i && cnt_o != SAT)  cnt_o <= cnt_o + 1'b1;
  end

  // count only advances on a tick
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !restart_i && !edge_i) |=> $stable(cnt_o));
  // saturated count never wraps back
  assert_sat_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == SAT && !restart_i && !edge_i) |=> cnt_o == SAT);
endmodule

// File: rtl/epm_classifier.sv
module epm_classifier
  import epm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          mode_i,
  input  logic          mode_chg_i,
  input  logic          lvl_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [CW:0]   cnt_i,
  input  logic [CW-1:0] lo_min_i,
  input  logic [CW-1:0] lo_max_i,
  input  logic [CW-1:0] hi_min_i,
  input  logic [CW-1:0] hi_max_i,
  output logic          restart_o,
  output logic          err_o,
  output logic          ok_o
);
  epm_state_e state, nxt, start_st;
  logic       err_n, ok_n, edge_w;
  logic [CW:0] win, lo_max_x, run_max, end_min, end_max;

  assign edge_w   = rise_i | fall_i;
  assign lo_max_x = {1'b0, lo_max_i};
  assign win      = {1'b0, lo_max_i} + {1'b0, hi_max_i};
  // limit of the phase now running (its level is the current level)
  assign run_max  = lvl_i ? {1'b0, hi_max_i} : {1'b0, lo_max_i};
  // limits of the phase an edge just closed (its level is the opposite)
  assign end_min  = lvl_i ? {1'b0, lo_min_i} : {1'b0, hi_min_i};
  assign end_max  = lvl_i ? {1'b0, lo_max_i} : {1'b0, hi_max_i};
  assign start_st = mode_i ? ST_PW_WAIT : (lvl_i ? ST_LP_ARM : ST_LP_START);

  always_comb begin
    nxt       = state;
    err_n     = 1'b0;
    ok_n      = 1'b0;
    restart_o = 1'b0;
    if (!en_i) begin
      nxt       = ST_OFF;
      restart_o = 1'b1;
    end else if (state == ST_OFF || mode_chg_i) begin
      nxt       = start_st;
      restart_o = 1'b1;
    end else begin
      case (state)
        ST_LP_ARM: if (fall_i) nxt = ST_LP_LOW;
        ST_LP_LOW: begin
          if (rise_i) begin
            restart_o = 1'b1;
            nxt       = start_st;
            if (cnt_i > lo_max_x) err_n = 1'b1;
            else                  ok_n  = 1'b1;
          end else if (cnt_i > lo_max_x) begin
            err_n     = 1'b1;
            restart_o = 1'b1;
            nxt       = start_st;
          end
        end
        ST_LP_START: begin
          if (rise_i) begin
            restart_o = 1'b1;
            nxt       = ST_LP_ARM;
          end else if (cnt_i > win) begin
            err_n     = 1'b1;
            restart_o = 1'b1;
          end
        end
        ST_PW_WAIT: begin
          if (edge_w) nxt = ST_PW_PH1;
          else if (cnt_i > win) begin
            err_n     = 1'b1;
            restart_o = 1'b1;
          end
        end
        ST_PW_PH1, ST_PW_PH2: begin
          if (edge_w) begin
            if (cnt_i < end_min || cnt_i > end_max) begin
              err_n     = 1'b1;
              restart_o = 1'b1;
              nxt       = ST_PW_WAIT;
            end else if (state == ST_PW_PH1) begin
              nxt = ST_PW_PH2;
            end else begin
              ok_n      = 1'b1;
              restart_o = 1'b1;
              nxt       = ST_PW_WAIT;
            end
          end else if (cnt_i > run_max) begin
            err_n     = 1'b1;
            restart_o = 1'b1;
            nxt       = ST_PW_WAIT;
          end
        end
        default: begin
          nxt       = ST_OFF;
          restart_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
      err_o <= 1'b0;
      ok_o  <= 1'b0;
    end else begin
      state <= nxt;
      err_o <= err_n;
      ok_o  <= ok_n;
    end
  end

  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(err_o && ok_o));
  assert_quiet_off_R1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!err_o && !ok_o));
  // a low-pulse-mode success is always judged at a rising edge
  assert_lp_ok_high_R2: assert property (@(posedge clk) disable iff (rst)
    (ok_o && !$past(mode_i)) |-> $past(lvl_i));
endmodule

// File: rtl/err_pulse_mon.sv
module err_pulse_mon #(
  parameter int CW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mcu_err_i,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          mode_pwm_i,
  input  logic [CW-1:0] lo_min_i,
  input  logic [CW-1:0] lo_max_i,
  input  logic [CW-1:0] hi_min_i,
  input  logic [CW-1:0] hi_max_i,
  output logic          err_o,
  output logic          ok_o
);
  logic        lvl, lvl_q, rise, fall, mode_q, restart;
  logic [CW:0] cnt;

  epm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(mcu_err_i), .q_o(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  always_ff @(posedge clk) mode_q <= mode_pwm_i;

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  epm_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .restart_i(restart), .edge_i(rise | fall),
    .tick_i(tick_i), .cnt_o(cnt)
  );

  epm_classifier #(.CW(CW)) u_cls (
    .clk(clk), .rst(rst), .en_i(en_i), .mode_i(mode_pwm_i),
    .mode_chg_i(mode_q != mode_pwm_i), .lvl_i(lvl), .rise_i(rise),
    .fall_i(fall), .cnt_i(cnt), .lo_min_i(lo_min_i), .lo_max_i(lo_max_i),
    .hi_min_i(hi_min_i), .hi_max_i(hi_max_i), .restart_o(restart),
    .err_o(err_o), .ok_o(ok_o)
  );

  assert_modeflip_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_pwm_i != $past(mode_pwm_i)) |=> (!err_o && !ok_o));
endmodule

// File: tb/err_pulse_mon_tb.sv
module err_pulse_mon_tb;
  localparam int CW = 12;

  logic clk = 1'b0, rst = 1'b1, pin = 1'b1, tick = 1'b1, en = 1'b0, mode = 1'b0;
  logic [CW-1:0] lo_min, lo_max, hi_min, hi_max;
  logic err_o, ok_o;

  int n_chk = 0, n_fail = 0, n_err = 0, n_ok = 0, n_dbl = 0;
  int cyc = 0, prev_err_cyc = -1, last_gap = 0;
  bit tick_alt = 1'b0, prev_err = 1'b0, prev_ok = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  err_pulse_mon #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .mcu_err_i(pin), .tick_i(tick), .en_i(en),
    .mode_pwm_i(mode), .lo_min_i(lo_min), .lo_max_i(lo_max),
    .hi_min_i(hi_min), .hi_max_i(hi_max), .err_o(err_o), .ok_o(ok_o)
  );

  always @(negedge clk) begin
    cyc++;
    tick <= tick_alt ? ~tick : 1'b1;
    if (err_o) begin
      if (prev_err_cyc >= 0) last_gap = cyc - prev_err_cyc;
      prev_err_cyc = cyc;
      n_err++;
    end
    if (ok_o) n_ok++;
    if ((err_o && ok_o) || (err_o && prev_err) || (ok_o && prev_ok)) n_dbl++;
    prev_err = err_o;
    prev_ok  = ok_o;
  end

  task automatic chk(bit good, string req, int act, int exp);
    #1;
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(bit v, int n);
    pin = v;
    cw(n);
  endtask

  task automatic enable_at(bit m, bit lvl);
    en = 1'b0; mode = m; pin = lvl;
    cw(6);
    en = 1'b1;
    cw(2);
  endtask

  task automatic finish_burst();
    cw(8);
    en = 1'b0;
    cw(4);
  endtask

  function automatic int mx(bit v);
    return v ? int'(hi_max) : int'(lo_max);
  endfunction
  function automatic int mn(bit v);
    return v ? int'(hi_min) : int'(lo_min);
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    int e0, o0, win;
    void'($urandom(32'h5EED));
    lo_min = 4; lo_max = 10; hi_min = 5; hi_max = 12;
    win = 22;
    cw(5);
    rst = 1'b0;
    cw(2);
    chk(!err_o && !ok_o, "R1 reset outputs", int'(err_o) + int'(ok_o), 0);

    // R2: low phase exactly at the maximum is correct
    e0 = n_err; o0 = n_ok;
    enable_at(0, 1); drive(1, 5); drive(0, 10); drive(1, 10); finish_burst();
    chk(n_ok - o0 == 1, "R2 low at max ok", n_ok - o0, 1);
    chk(n_err - e0 == 0, "R2 low at max no err", n_err - e0, 0);

    // R3: one tick past the maximum
    e0 = n_err; o0 = n_ok;
    enable_at(0, 1); drive(1, 5); drive(0, 11); drive(1, 10); finish_burst();
    chk(n_err - e0 == 1, "R3 low max+1 err", n_err - e0, 1);
    chk(n_ok - o0 == 0, "R3 low max+1 no ok", n_ok - o0, 0);

    // R3: error raised while the pin is still low
    e0 = n_err; o0 = n_ok;
    enable_at(0, 1); drive(1, 5); drive(0, 18);
    chk(n_err - e0 == 1, "R3 err before rise", n_err - e0, 1);
    drive(1, 10); finish_burst();
    chk(n_err - e0 == 1 && n_ok == o0, "R3 single err total", n_err - e0, 1);

    // R4: start-up time-out with pin low, repeated
    e0 = n_err; o0 = n_ok; prev_err_cyc = -1; last_gap = 0;
    enable_at(0, 0); cw(4 * (win + 2) + 10);
    chk(n_err - e0 >= 3, "R4 startup errors", n_err - e0, 3);
    chk(last_gap == win + 2, "R4 startup spacing", last_gap, win + 2);
    drive(1, 4); finish_burst();
    chk(n_ok == o0, "R4 no ok", n_ok - o0, 0);

    // R2: pin high at enable waits for a fall without time-out
    e0 = n_err;
    enable_at(0, 1); cw(3 * win); finish_burst();
    chk(n_err == e0, "R2 idle high quiet", n_err - e0, 0);

    // R5: in-range low (at min) then high (at max)
    e0 = n_err; o0 = n_ok;
    enable_at(1, 1); drive(1, 2); drive(0, 4); drive(1, 12); drive(0, 6); finish_burst();
    chk(n_ok - o0 == 1, "R5 pwm pair ok", n_ok - o0, 1);
    chk(n_err == e0, "R5 pwm pair no err", n_err - e0, 0);

    // R6: low one tick under min
    e0 = n_err; o0 = n_ok;
    enable_at(1, 1); drive(1, 2); drive(0, 3); drive(1, 5); finish_burst();
    chk(n_err - e0 == 1 && n_ok == o0, "R6 short low err", n_err - e0, 1);

    // R7: high at max+1 closes at edge with error
    e0 = n_err; o0 = n_ok;
    enable_at(1, 1); drive(1, 2); drive(0, 5); drive(1, 13); drive(0, 3); finish_burst();
    chk(n_err - e0 == 1 && n_ok == o0, "R7 high max+1 err", n_err - e0, 1);

    // R7: long high flagged before its closing edge
    e0 = n_err; o0 = n_ok;
    enable_at(1, 1); drive(1, 2); drive(0, 5); drive(1, 20);
    chk(n_err - e0 == 1, "R7 err before edge", n_err - e0, 1);
    drive(0, 1); finish_burst();
    chk(n_err - e0 == 1 && n_ok == o0, "R7 single err", n_err - e0, 1);

    // R8: no edge in PWM mode
    e0 = n_err; o0 = n_ok; prev_err_cyc = -1; last_gap = 0;
    enable_at(1, 1); cw(4 * (win + 2) + 10); finish_burst();
    chk(n_err - e0 >= 3, "R8 timeout errors", n_err - e0, 3);
    chk(last_gap == win + 2, "R8 timeout spacing", last_gap, win + 2);

    // R9: mode change mid low pulse discards it
    e0 = n_err; o0 = n_ok;
    enable_at(0, 1); drive(1, 4); drive(0, 4); mode = 1'b1; drive(0, 14);
    drive(1, 1); finish_burst();
    chk(n_err == e0 && n_ok == o0, "R9 mode flip quiet", n_err - e0 + n_ok - o0, 0);

    // R1: enable drop mid pulse, then a fresh cycle
    e0 = n_err; o0 = n_ok;
    enable_at(0, 1); drive(1, 4); drive(0, 4); en = 1'b0; drive(0, 20);
    chk(n_err == e0 && n_ok == o0, "R1 disabled quiet", n_err - e0 + n_ok - o0, 0);
    drive(1, 4); en = 1'b1; drive(1, 3); drive(0, 6); drive(1, 8); finish_burst();
    chk(n_ok - o0 == 1 && n_err == e0, "R1 restart ok", n_ok - o0, 1);

    // R10: tick every other cycle halves measured length
    e0 = n_err; o0 = n_ok; tick_alt = 1'b1;
    enable_at(0, 1); drive(1, 4); drive(0, 16); drive(1, 10);
    drive(0, 28); drive(1, 10); finish_burst();
    tick_alt = 1'b0;
    chk(n_ok - o0 == 1, "R10 slow tick ok", n_ok - o0, 1);
    chk(n_err - e0 == 1, "R10 slow tick err", n_err - e0, 1);

    // random low-pulse bursts (R2, R3)
    for (int b = 0; b < 12; b++) begin
      int ee, eo, np;
      lo_min = CW'($urandom_range(8, 3));
      lo_max = lo_min + CW'($urandom_range(10, 4));
      hi_min = CW'($urandom_range(8, 3));
      hi_max = hi_min + CW'($urandom_range(10, 4));
      ee = 0; eo = 0; e0 = n_err; o0 = n_ok;
      enable_at(0, 1);
      drive(1, int'($urandom_range(8, 1)));
      np = int'($urandom_range(8, 3));
      for (int k = 0; k < np; k++) begin
        int lw;
        lw = int'($urandom_range(int'(lo_max) + 3, 1));
        drive(0, lw);
        drive(1, int'($urandom_range(10, 1)));
        if (lw <= int'(lo_max)) eo++; else ee++;
      end
      finish_burst();
      chk(n_ok - o0 == eo, "R2 random low ok", n_ok - o0, eo);
      chk(n_err - e0 == ee, "R3 random low err", n_err - e0, ee);
    end

    // random PWM bursts (R5, R6, R7)
    for (int b = 0; b < 20; b++) begin
      int ee, eo, np, st, pl;
      bit v, pv;
      lo_min = CW'($urandom_range(8, 3));
      lo_max = lo_min + CW'($urandom_range(10, 4));
      hi_min = CW'($urandom_range(8, 3));
      hi_max = hi_min + CW'($urandom_range(10, 4));
      ee = 0; eo = 0; st = 0; pl = 0; pv = 1'b0; e0 = n_err; o0 = n_ok;
      v = 1'($urandom_range(1, 0));
      enable_at(1, v);
      drive(v, 2);
      v = ~v;
      np = int'($urandom_range(10, 3));
      for (int k = 0; k < np; k++) begin
        int lw;
        if (st == 0) st = 1;
        else if (pl < mn(pv) || pl > mx(pv)) begin ee++; st = 0; end
        else if (st == 1) st = 2;
        else begin eo++; st = 0; end
        if (k == np - 1) begin
          pin = v;
        end else begin
          lw = int'($urandom_range(mx(v) + 3, 1));
          drive(v, lw);
          if (st != 0 && lw >= mx(v) + 2) begin ee++; st = 0; end
          pv = v; pl = lw;
        end
        v = ~v;
      end
      finish_burst();
      chk(n_ok - o0 == eo, "R5 random pwm ok", n_ok - o0, eo);
      chk(n_err - e0 == ee, "R6 R7 random pwm err", n_err - e0, ee);
    end

    chk(n_dbl == 0, "R11 exclusive single-cycle pulses", n_dbl, 0);
    done = 1'b1;
    report();
    $finish;
  end
endmodule